// File: doc/BRIEF.md
# Canary-Path Timing Error Monitor

This block sits next to a larger design and gives early warning that the clock has become too fast for the present voltage and temperature. It carries a single bit around a private loop, with no link to the main datapath: a launch register flips its value on every clock. That bit passes through a chain of inverting stages built to be slower than the main design's worst register-to-register path by a margin. A capture register then samples the far end of the chain. Because the launched value changes on every cycle, each cycle pushes a full transition through the whole chain. When the chain is too slow for the clock, the capture register samples a stale value, and the block sees this before the main design fails.

A checker works out the value the capture register should hold, using the launch register and the chain parity. On the first disagreement it raises an error flag, and the flag stays set until reset. A clock controller reads the flag and lowers the frequency. The monitor has no notion of real delay in simulation. Instead, a test-only fault input inverts the bit at the capture register, which lets the sticky flag be exercised.

Top module: `tmon_canary`

## Requirements
- R1: While reset is low, and for the cycles just after it rises, `err_o` is 0.
- R2: The chain has `NUM_STAGES` inverting stages. The captured bit equals the previously launched bit inverted when `NUM_STAGES` is odd, and equal to it when `NUM_STAGES` is even.
- R3: After reset the launch register holds 0. It inverts on every clock edge, so the first launched value after reset is 1.
- R4: If the captured bit mismatches in cycle k+1, because of a fault driven in cycle k with k ≥ 1, `err_o` is 1 from cycle k+2. Cycle 0 is the cycle in which reset rises.
- R5: Once set, `err_o` stays 1 whatever the fault input does, until reset is asserted again.
- R6: Mismatches seen at the capture register in cycles 0 and 1 are ignored. A fault driven only in cycle 0 leaves `err_o` at 0.
- R7: When `fault_inj_i` is 1, the bit stored by the capture register at the next edge is inverted. A fault held for several cycles still sets the flag once.
- R8: With `fault_inj_i` held at 0, `err_o` stays 0 indefinitely, for both odd and even chain lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared with the monitored design |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk_i |
| fault_inj_i | input | 1 | Test-only: inverts the captured bit; tie to 0 in use |
| err_o | output | 1 | Sticky timing-error flag |

## Verification
On every cycle, the assertions check four things: the launch bit toggles, the captured bit matches the chain parity unless a fault was injected, the flag cannot rise without a fault two cycles earlier, and once high the flag stays high. The bench scenarios show the remaining behaviour: the exact cycle in which the flag first rises, the masking of a fault in the first cycle after reset, clearing by a fresh reset, and silence over long fault-free runs for an even chain as well as an odd one.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  function automatic logic chain_inverts(input int unsigned stages);
    return logic'(stages % 2);
  endfunction
endpackage

// File: rtl/tmon_launch.sv
module tmon_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = ~q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tmon_chain.sv
module tmon_chain #(
  parameter int unsigned NUM_STAGES = 7
) (
  input  logic a_i,
  output logic y_o
);
  logic [NUM_STAGES:0] node;

  assign node[0] = a_i;
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    assign node[g+1] = ~node[g];
  end
  assign y_o = node[NUM_STAGES];
endmodule

// File: rtl/tmon_capture.sv
module tmon_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  input  logic flip_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = d_i ^ flip_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tmon_check.sv
module tmon_check #(
  parameter int unsigned NUM_STAGES = 7,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic capt_i,
  output logic err_o
);
  import tmon_pkg::*;

  localparam logic        INV   = chain_inverts(NUM_STAGES);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;
  logic             armed, expect_bit, mismatch;
  logic             err_d, err_q;

  always_comb begin
    armed      = (cnt_q == CNT_MAX);
    cnt_en     = !armed;
    cnt_d      = cnt_q + 1'b1;
    // launch has already flipped since the captured bit left it
    expect_bit = ~launch_i ^ INV;
    mismatch   = (capt_i != expect_bit);
    err_d      = err_q | (armed & mismatch);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/tmon_canary.sv
module tmon_canary #(
  parameter int unsigned NUM_STAGES = 7,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_inj_i,
  output logic err_o
);
  logic launch_q;
  logic chain_out;
  logic capt_q;

  tmon_launch u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .q_o    (launch_q)
  );

  tmon_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
    .a_i (launch_q),
    .y_o (chain_out)
  );

  tmon_capture u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .d_i    (chain_out),
    .flip_i (fault_inj_i),
    .q_o    (capt_q)
  );

  tmon_check #(.NUM_STAGES(NUM_STAGES), .SETTLE_CYC(SETTLE_CYC)) u_check (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch_q),
    .capt_i   (capt_q),
    .err_o    (err_o)
  );
endmodule

// File: rtl/tmon_canary_chk.sv
module tmon_canary_chk #(
  parameter int unsigned NUM_STAGES = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fault_inj_i,
  input logic err_o,
  input logic launch_q,
  input logic capt_q
);
  localparam logic INV = logic'(NUM_STAGES % 2);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !err_o);

  p_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !$past(fault_inj_i)) |-> (capt_q == (~launch_q ^ INV)));

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0) |-> (launch_q != $past(launch_q)));

  p_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(fault_inj_i, 2));

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd3) |-> !err_o);
endmodule

bind tmon_canary tmon_canary_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fault_inj_i (fault_inj_i),
  .err_o       (err_o),
  .launch_q    (launch_q),
  .capt_q      (capt_q)
);

// File: tb/tmon_canary_tb.sv
module tmon_canary_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic fault;
  logic err, err_even;
  int   n_checks = 0;
  int   n_errors = 0;

  always #2 clk = ~clk;

  tmon_canary #(.NUM_STAGES(7)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_inj_i(fault), .err_o(err));

  tmon_canary #(.NUM_STAGES(4)) u_dut_even (
    .clk_i(clk), .rst_ni(rst_n), .fault_inj_i(1'b0), .err_o(err_even));

  typedef struct packed {
    logic [7:0] fc;
    logic [7:0] len;
    logic       exp_err;
  } vec_t;

  // fault start cycle, fault length, expected flag after the run
  localparam vec_t VECS [6] = '{
    '{fc: 8'd0,   len: 8'd1, exp_err: 1'b0},  // R6
    '{fc: 8'd1,   len: 8'd1, exp_err: 1'b1},  // R4 first checked
    '{fc: 8'd6,   len: 8'd1, exp_err: 1'b1},  // R4
    '{fc: 8'd3,   len: 8'd3, exp_err: 1'b1},  // R7 held fault
    '{fc: 8'hFF,  len: 8'd0, exp_err: 1'b0},  // R8 R3 no fault
    '{fc: 8'd12,  len: 8'd1, exp_err: 1'b1}   // R5 late fault then idle
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fault = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;   // start of cycle 0
  endtask

  initial begin
    for (int w = 0; w < 5000; w++) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fault = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset odd", err, 1'b0);
    check("R1 reset even", err_even, 1'b0);

    for (int v = 0; v < 6; v++) begin
      do_reset();
      for (int c = 0; c < 24; c++) begin
        fault = (c >= int'(VECS[v].fc)) && (c < int'(VECS[v].fc) + int'(VECS[v].len));
        @(negedge clk);
      end
      fault = 1'b0;
      @(negedge clk);
      check($sformatf("R4 R5 R6 R7 vector %0d", v), err, VECS[v].exp_err);
      check("R2 R8 even chain quiet", err_even, 1'b0);
    end

    // latency: fault in cycle 5, flag rises in cycle 7
    do_reset();
    for (int c = 0; c < 5; c++) @(negedge clk);
    fault = 1'b1;
    @(negedge clk);          // cycle 6
    fault = 1'b0;
    check("R4 not yet in cycle k+1", err, 1'b0);
    @(negedge clk);          // cycle 7
    check("R4 set in cycle k+2", err, 1'b1);

    // sticky
    for (int c = 0; c < 40; c++) @(negedge clk);
    check("R5 sticky", err, 1'b1);

    // reset clears
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 R5 cleared by reset", err, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < 2; c++) @(negedge clk);
    check("R1 low after release", err, 1'b0);

    // long fault-free run
    for (int c = 0; c < 300; c++) @(negedge clk);
    check("R2 R3 R8 odd quiet", err, 1'b0);
    check("R2 R8 even quiet", err_even, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule